// File: doc/BRIEF.md
# External Interrupt Controller

This block watches 32 external input pins, grouped into four banks of eight. Each pin has its own trigger type. The available types are active-low level, active-high level, falling edge, rising edge and both edges. When a pin's trigger condition occurs, the block latches an event into that pin's pending bit. Software configures the block and services it through a small register port. The port has a single address, a write strobe, write data and combinational read data. Each bank has three registers:

- a trigger-type register,
- a mask register,
- a pending register. Writing a one to a bit of this register clears that bit.

Each of the low sixteen pins drives its own interrupt line to the next level of interrupt handling. The upper sixteen pins share one line. Each line is high while at least one of its pins is pending and unmasked. Every pin passes through a two-flop synchroniser before detection. Edges are found by comparing the synchronised sample with the sample from the previous cycle.

The register address is made of a 2-bit register kind in the top bits and a bank index in the low bits. The kinds are 0 = trigger type, 1 = mask, 2 = pending and 3 = unused. With the default sizes the address is 4 bits wide: `{kind[1:0], bank[1:0]}`.

Top module: `eint_ctrl`

## Requirements
- R1: After reset, every trigger field holds code 7 (disabled), every mask register reads 0xFF, every pending register reads 0, and all interrupt lines are low.
- R2: The trigger field of pin p occupies bits [4*(p%8)+2 : 4*(p%8)] of the trigger register of bank p/8, and bit 4*(p%8)+3 reads 0. Mask and pending registers hold only bits [7:0], and their upper bits read 0. Kind 3 reads 0 and ignores writes.
- R3: Code 3 latches an event on a 0-to-1 change of the synchronised pin. Code 2 latches on a 1-to-0 change. Code 4 latches on either change. The pending bit becomes visible after the third rising clock edge that follows the pin change.
- R4: Code 1 (high level) and code 0 (low level) set the pending bit on every cycle in which the synchronised pin sits at the active level. A clear issued during that time therefore does not take effect.
- R5: Codes 5, 6 and 7 never set a pending bit, whatever the pin does.
- R6: Writing 1 to a pending bit clears it on the next clock edge. Writing 0 leaves the bit unchanged.
- R7: When an event and a clear of the same pending bit occur on the same clock edge, the bit ends up set.
- R8: A mask bit of 1 keeps its pin off every interrupt line, but the pending bit still latches. A mask bit of 0 lets the pin through.
- R9: `irq_line_o[p]`, for p = 0..15, is high exactly when pin p is pending and unmasked.
- R10: `irq_shared_o` is high exactly when at least one of pins 16..31 is pending and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 32 | Asynchronous external pins |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address {kind, bank} |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_line_o | output | 16 | Dedicated interrupt lines for pins 0..15 |
| irq_shared_o | output | 1 | Combined interrupt line for pins 16..31 |

## Verification
A corrupted pending or mask bit shows up on its interrupt line in the same cycle. It also shows up in the pending readback on the next access. A wrong trigger decode or a wrong synchroniser depth changes the cycle on which a line rises. The three-edge latency from pin to line is therefore checked exactly: the line must still be low after two edges and high after the third. A stuck clear, or a clear that beats a coincident event, shows one cycle after the write.

// File: rtl/eint_pkg.sv
// Package: shared encodings for the external interrupt controller.
// Assumes trigger fields are 3 bits wide inside 4-bit nibbles.
package eint_pkg;

    localparam int TRIG_W      = 3;
    localparam int TRIG_STRIDE = 4;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_LVL_LO = 3'd0,
        TRIG_LVL_HI = 3'd1,
        TRIG_FALL   = 3'd2,
        TRIG_RISE   = 3'd3,
        TRIG_BOTH   = 3'd4,
        TRIG_OFF5   = 3'd5,
        TRIG_OFF6   = 3'd6,
        TRIG_OFF    = 3'd7
    } trig_e;

    typedef enum logic [1:0] {
        KIND_TRIG = 2'd0,
        KIND_MASK = 2'd1,
        KIND_PEND = 2'd2,
        KIND_NONE = 2'd3
    } reg_kind_e;

endpackage

// File: rtl/eint_sync.sv
// Module: eint_sync
// Two-flop synchroniser per pin, followed by one more stage that holds the
// previous synchronised sample for edge detection.
// Assumes pins are asynchronous and are held low while reset is active.
module eint_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] cur_q;
    logic [WIDTH-1:0] prev_q;

    // Purpose: move the pins into the clock domain and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/eint_detect.sv
// Module: eint_detect
// Decodes one pin's trigger code against its current and previous
// synchronised samples and flags an event for this cycle.
// Assumes codes outside the five defined types mean "disabled".
module eint_detect
    import eint_pkg::*;
(
    input  logic [TRIG_W-1:0] trig_i,
    input  logic              cur_i,
    input  logic              prev_i,
    output logic              evt_o
);

    trig_e trig;
    assign trig = trig_e'(trig_i);

    // Purpose: pick the event condition that matches the trigger type.
    always_comb begin
        case (trig)
            TRIG_LVL_LO: evt_o = ~cur_i;
            TRIG_LVL_HI: evt_o = cur_i;
            TRIG_FALL:   evt_o = prev_i & ~cur_i;
            TRIG_RISE:   evt_o = ~prev_i & cur_i;
            TRIG_BOTH:   evt_o = prev_i ^ cur_i;
            default:     evt_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/eint_bank.sv
// Module: eint_bank
// Holds one bank's trigger fields, mask and pending bits, and runs one
// detector per pin. A clear write and a same-cycle event resolve to "set".
// Assumes DATA_W is wide enough for PINS nibbles.
module eint_bank
    import eint_pkg::*;
#(
    parameter int PINS   = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   cur_i,
    input  logic [PINS-1:0]   prev_i,
    input  logic              trig_we_i,
    input  logic              mask_we_i,
    input  logic              clr_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [PINS-1:0]   pend_o,
    output logic [PINS-1:0]   mask_o,
    output logic [PINS-1:0]   evt_o,
    output logic [DATA_W-1:0] trig_rd_o
);

    logic [PINS-1:0][TRIG_W-1:0] trig_q;
    logic [PINS-1:0]             mask_q;
    logic [PINS-1:0]             pend_q;
    logic [PINS-1:0]             clr_bits;

    // Purpose: hold the per-pin trigger fields; a write keeps the low 3 bits of each nibble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PINS; i++) begin
                trig_q[i] <= TRIG_OFF;
            end
        end else if (trig_we_i) begin
            for (int i = 0; i < PINS; i++) begin
                trig_q[i] <= wdata_i[i*TRIG_STRIDE +: TRIG_W];
            end
        end
    end

    // Purpose: hold the mask bits; every pin starts masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (mask_we_i) begin
            mask_q <= wdata_i[PINS-1:0];
        end
    end

    // Purpose: select the pending bits that this cycle's write clears.
    always_comb begin
        clr_bits = '0;
        if (clr_we_i) begin
            clr_bits = wdata_i[PINS-1:0];
        end
    end

    // Purpose: latch events; an event overrides a clear of the same bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_bits) | evt_o;
        end
    end

    // One detector per pin.
    for (genvar g = 0; g < PINS; g++) begin : g_det
        eint_detect u_det (
            .trig_i (trig_q[g]),
            .cur_i  (cur_i[g]),
            .prev_i (prev_i[g]),
            .evt_o  (evt_o[g])
        );
    end

    // Purpose: pack the trigger fields into nibbles for readback; spare bits read 0.
    always_comb begin
        trig_rd_o = '0;
        for (int i = 0; i < PINS; i++) begin
            trig_rd_o[i*TRIG_STRIDE +: TRIG_W] = trig_q[i];
        end
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;

endmodule

// File: rtl/eint_ctrl.sv
// Module: eint_ctrl (top)
// External interrupt controller. Pins are grouped into banks; each bank has
// trigger, mask and pending registers on a simple register port. The low
// DIRECT_PINS pins each drive their own line; all remaining pins share one.
// Assumes DIRECT_PINS < NUM_BANKS*BANK_PINS and that reads are combinational.
module eint_ctrl
    import eint_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int BANK_PINS   = 8,
    parameter int DIRECT_PINS = 16,
    parameter int DATA_W      = 32,
    localparam int NUM_PINS   = NUM_BANKS * BANK_PINS,
    localparam int BANK_BITS  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W     = BANK_BITS + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PINS-1:0]    pin_i,
    input  logic                   reg_we_i,
    input  logic [ADDR_W-1:0]      reg_addr_i,
    input  logic [DATA_W-1:0]      reg_wdata_i,
    output logic [DATA_W-1:0]      reg_rdata_o,
    output logic [DIRECT_PINS-1:0] irq_line_o,
    output logic                   irq_shared_o
);

    logic [NUM_PINS-1:0]               cur;
    logic [NUM_PINS-1:0]               prev;
    logic [NUM_PINS-1:0]               pend_all;
    logic [NUM_PINS-1:0]               mask_all;
    logic [NUM_PINS-1:0]               evt_all;
    logic [NUM_PINS-1:0]               active;
    logic [NUM_BANKS-1:0][DATA_W-1:0]  trig_rd;
    logic [NUM_BANKS-1:0]              trig_we;
    logic [NUM_BANKS-1:0]              mask_we;
    logic [NUM_BANKS-1:0]              clr_we;
    reg_kind_e                         kind;
    logic [BANK_BITS-1:0]              bank_sel;

    assign kind     = reg_kind_e'(reg_addr_i[ADDR_W-1 -: 2]);
    assign bank_sel = reg_addr_i[BANK_BITS-1:0];

    // Synchroniser for all pins.
    eint_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .cur_o  (cur),
        .prev_o (prev)
    );

    // One bank per group of BANK_PINS pins, with its own write decode.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign trig_we[b] = reg_we_i && (kind == KIND_TRIG) && (bank_sel == BANK_BITS'(b));
        assign mask_we[b] = reg_we_i && (kind == KIND_MASK) && (bank_sel == BANK_BITS'(b));
        assign clr_we[b]  = reg_we_i && (kind == KIND_PEND) && (bank_sel == BANK_BITS'(b));

        eint_bank #(.PINS(BANK_PINS), .DATA_W(DATA_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .cur_i     (cur[b*BANK_PINS +: BANK_PINS]),
            .prev_i    (prev[b*BANK_PINS +: BANK_PINS]),
            .trig_we_i (trig_we[b]),
            .mask_we_i (mask_we[b]),
            .clr_we_i  (clr_we[b]),
            .wdata_i   (reg_wdata_i),
            .pend_o    (pend_all[b*BANK_PINS +: BANK_PINS]),
            .mask_o    (mask_all[b*BANK_PINS +: BANK_PINS]),
            .evt_o     (evt_all[b*BANK_PINS +: BANK_PINS]),
            .trig_rd_o (trig_rd[b])
        );
    end

    // Purpose: return the register selected by the address; unused kinds read 0.
    always_comb begin
        reg_rdata_o = '0;
        if (int'(bank_sel) < NUM_BANKS) begin
            case (kind)
                KIND_TRIG: reg_rdata_o = trig_rd[bank_sel];
                KIND_MASK: reg_rdata_o = DATA_W'(mask_all[int'(bank_sel)*BANK_PINS +: BANK_PINS]);
                KIND_PEND: reg_rdata_o = DATA_W'(pend_all[int'(bank_sel)*BANK_PINS +: BANK_PINS]);
                default:   reg_rdata_o = '0;
            endcase
        end
    end

    // Purpose: a pin requests service while it is pending and unmasked.
    assign active       = pend_all & ~mask_all;
    assign irq_line_o   = active[DIRECT_PINS-1:0];
    assign irq_shared_o = |active[NUM_PINS-1:DIRECT_PINS];

endmodule

// File: rtl/eint_ctrl_chk.sv
// Module: eint_ctrl_chk
// Checker bound into eint_ctrl. It watches pending, mask and event vectors
// together with the register port and the interrupt lines.
module eint_ctrl_chk #(
    parameter int NUM_PINS    = 32,
    parameter int DIRECT_PINS = 16,
    parameter int BANK_PINS   = 8,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   reg_we_i,
    input logic [ADDR_W-1:0]      reg_addr_i,
    input logic [DATA_W-1:0]      reg_wdata_i,
    input logic [NUM_PINS-1:0]    pend_i,
    input logic [NUM_PINS-1:0]    mask_i,
    input logic [NUM_PINS-1:0]    evt_i,
    input logic [DIRECT_PINS-1:0] irq_line_i,
    input logic                   irq_shared_i
);

    localparam logic [ADDR_W-1:0] PEND_BANK0 = ADDR_W'(2) << (ADDR_W - 2);

    // R1: a reset cycle leaves pending clear and every pin masked.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pend_i == '0 && mask_i == '1));

    // R3: a pending bit can only rise after a detected event.
    assert_set_needs_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & ~$past(pend_i) & ~$past(evt_i)) == '0));

    // R7: an event always leaves its pending bit set, clear or not.
    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & $past(evt_i)) == $past(evt_i)));

    // R6: a clear of bank 0 removes every written bit that had no event.
    assert_clear_bank0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_addr_i == PEND_BANK0) |=>
        ((pend_i[BANK_PINS-1:0] & $past(reg_wdata_i[BANK_PINS-1:0])
          & ~$past(evt_i[BANK_PINS-1:0])) == '0));

    // R8: a masked pin never reaches its dedicated line.
    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_line_i & mask_i[DIRECT_PINS-1:0]) == '0));

    // R9: a dedicated line is high only for a pending pin.
    assert_line_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_line_i & ~pend_i[DIRECT_PINS-1:0]) == '0));

    // R10: the shared line implies some upper pin is pending.
    assert_shared_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_shared_i |-> (pend_i[NUM_PINS-1:DIRECT_PINS] != '0));

endmodule

bind eint_ctrl eint_ctrl_chk #(
    .NUM_PINS    (NUM_PINS),
    .DIRECT_PINS (DIRECT_PINS),
    .BANK_PINS   (BANK_PINS),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we_i     (reg_we_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .pend_i       (pend_all),
    .mask_i       (mask_all),
    .evt_i        (evt_all),
    .irq_line_i   (irq_line_o),
    .irq_shared_i (irq_shared_o)
);

// File: tb/eint_ctrl_tb.sv
`timescale 1ns/1ps
module eint_ctrl_tb;

    localparam int NB = 4;
    localparam int BP = 8;
    localparam int NP = 32;
    localparam int DP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] irq_line;
    logic        irq_shared;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    bit compare_on = 0;

    always #2.5 clk = ~clk;

    eint_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_i        (pins),
        .reg_we_i     (reg_we),
        .reg_addr_i   (reg_addr),
        .reg_wdata_i  (reg_wdata),
        .reg_rdata_o  (reg_rdata),
        .irq_line_o   (irq_line),
        .irq_shared_o (irq_shared)
    );

    // ---------------- reference model built from the requirements ----------------
    logic [31:0] m_s1, m_s2, m_p, m_pend;
    logic [31:0] m_cfg [NB];
    logic [7:0]  m_mask [NB];

    function automatic logic model_evt(input logic [2:0] code, input logic s, input logic p);
        case (code)
            3'd0: return !s;
            3'd1: return s;
            3'd2: return p && !s;
            3'd3: return !p && s;
            3'd4: return p ^ s;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] model_events();
        logic [31:0] e;
        for (int i = 0; i < NP; i++) begin
            e[i] = model_evt(m_cfg[i/BP][4*(i%BP) +: 3], m_s2[i], m_p[i]);
        end
        return e;
    endfunction

    function automatic logic [31:0] model_active();
        logic [31:0] a;
        for (int b = 0; b < NB; b++) begin
            a[b*BP +: BP] = m_pend[b*BP +: BP] & ~m_mask[b];
        end
        return a;
    endfunction

    function automatic logic [31:0] model_read(input logic [3:0] addr);
        case (addr[3:2])
            2'd0: return m_cfg[addr[1:0]];
            2'd1: return {24'h0, m_mask[addr[1:0]]};
            2'd2: return {24'h0, m_pend[addr[1:0]*BP +: BP]};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_p <= '0; m_pend <= '0;
            for (int b = 0; b < NB; b++) begin
                m_cfg[b]  <= 32'h77777777;
                m_mask[b] <= 8'hFF;
            end
        end else begin
            logic [31:0] clr;
            clr = '0;
            if (reg_we && reg_addr[3:2] == 2'd2) clr[reg_addr[1:0]*BP +: BP] = reg_wdata[7:0];
            m_pend <= (m_pend & ~clr) | model_events();
            m_s1 <= pins; m_s2 <= m_s1; m_p <= m_s2;
            if (reg_we && reg_addr[3:2] == 2'd0) m_cfg[reg_addr[1:0]] <= reg_wdata & 32'h77777777;
            if (reg_we && reg_addr[3:2] == 2'd1) m_mask[reg_addr[1:0]] <= reg_wdata[7:0];
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    localparam logic [3:0] A_TRIG0 = 4'h0, A_TRIG1 = 4'h1, A_TRIG2 = 4'h2;
    localparam logic [3:0] A_MASK0 = 4'h4, A_MASK1 = 4'h5, A_MASK2 = 4'h6;
    localparam logic [3:0] A_PEND0 = 4'h8, A_PEND1 = 4'h9, A_PEND2 = 4'hA;

    // ---------------- watchdog ----------------
    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        step(4);
        rst_n = 1'b1;
        step(1);

        // R1: reset values of all registers and lines
        for (int b = 0; b < NB; b++) begin
            rd(4'(b), v);      chk("R1 trig reset", v, 32'h77777777);
            rd(4'(4 + b), v);  chk("R1 mask reset", v, 32'h000000FF);
            rd(4'(8 + b), v);  chk("R1 pend reset", v, 32'h0);
        end
        chk("R1 lines reset", {15'h0, irq_shared, irq_line}, 32'h0);

        // R2: field packing, spare bits and unused kind
        wr(A_TRIG1, 32'h89ABCDEF);
        rd(A_TRIG1, v); chk("R2 trig field packing", v, 32'h01234567);
        wr(A_TRIG1, 32'h77777777);
        wr(A_MASK2, 32'hFFFFFF00);
        rd(A_MASK2, v); chk("R2 mask upper bits", v, 32'h0);
        wr(A_MASK2, 32'h000000FF);
        wr(4'hC, 32'hFFFFFFFF);
        rd(4'hC, v); chk("R2 unused kind reads 0", v, 32'h0);

        // R3: rising edge on pin 0 with exact latency
        wr(A_TRIG0, 32'h77777773);
        wr(A_MASK0, 32'h000000FE);
        pins[0] = 1'b1;
        step(2);
        chk("R3 latency two edges", {31'h0, irq_line[0]}, 32'h0);
        step(1);
        chk("R3 rising after three edges", {31'h0, irq_line[0]}, 32'h1);
        rd(A_PEND0, v); chk("R3 pend after rise", v, 32'h01);
        wr(A_PEND0, 32'h00);
        rd(A_PEND0, v); chk("R6 write zero keeps pend", v, 32'h01);
        wr(A_PEND0, 32'h01);
        rd(A_PEND0, v); chk("R6 write one clears", v, 32'h00);
        chk("R6 line drops after clear", {31'h0, irq_line[0]}, 32'h0);
        pins[0] = 1'b0; step(4);
        rd(A_PEND0, v); chk("R3 rising ignores fall", v, 32'h00);

        // R3: falling edge on pin 0
        wr(A_TRIG0, 32'h77777772);
        pins[0] = 1'b1; step(4);
        rd(A_PEND0, v); chk("R3 falling ignores rise", v, 32'h00);
        pins[0] = 1'b0; step(3);
        rd(A_PEND0, v); chk("R3 falling sets", v, 32'h01);
        wr(A_PEND0, 32'h01);

        // R4: high level on pin 1 re-asserts after clear
        wr(A_TRIG0, 32'h77777712);
        wr(A_MASK0, 32'h000000FC);
        pins[1] = 1'b1; step(3);
        rd(A_PEND0, v); chk("R4 high level sets", v, 32'h02);
        wr(A_PEND0, 32'h02);
        rd(A_PEND0, v); chk("R4 level persists past clear", v, 32'h02);
        pins[1] = 1'b0; step(3);
        wr(A_PEND0, 32'h02);
        rd(A_PEND0, v); chk("R4 clear after level ends", v, 32'h00);
        // R4: low level on pin 1
        wr(A_TRIG0, 32'h77777702);
        step(1);
        rd(A_PEND0, v); chk("R4 low level sets", v, 32'h02);
        pins[1] = 1'b1; step(3);
        wr(A_PEND0, 32'h02);
        rd(A_PEND0, v); chk("R4 low level cleared when high", v, 32'h00);
        wr(A_TRIG0, 32'h77777777);
        pins[1] = 1'b0; step(3);

        // R5: disabled codes on pin 2
        for (int c = 5; c < 8; c++) begin
            wr(A_TRIG0, 32'h77777077 | (32'(c) << 8));
            pins[2] = 1'b1; step(4);
            pins[2] = 1'b0; step(4);
            rd(A_PEND0, v); chk("R5 disabled code no pend", v, 32'h00);
        end

        // R8: masked pin 3 still latches
        wr(A_TRIG0, 32'h77773777);
        wr(A_MASK0, 32'h000000FF);
        pins[3] = 1'b1; step(3);
        chk("R8 masked line low", {16'h0, irq_line}, 32'h0);
        rd(A_PEND0, v); chk("R8 masked pend latches", v, 32'h08);
        wr(A_MASK0, 32'h000000F7);
        chk("R8 unmask raises line", {16'h0, irq_line}, 32'h0008);
        wr(A_PEND0, 32'h08);
        pins[3] = 1'b0;

        // R7: both-edge pin 4, clear coinciding with the falling event
        wr(A_TRIG0, 32'h77747777);
        wr(A_MASK0, 32'h000000EF);
        pins[4] = 1'b1; step(3);
        rd(A_PEND0, v); chk("R3 both edges on rise", v, 32'h10);
        pins[4] = 1'b0;
        step(2);
        reg_we = 1'b1; reg_addr = A_PEND0; reg_wdata = 32'h10;
        step(1);
        reg_we = 1'b0;
        rd(A_PEND0, v); chk("R7 event beats clear", v, 32'h10);
        wr(A_PEND0, 32'h10);
        rd(A_PEND0, v); chk("R6 later clear works", v, 32'h00);

        // R10: shared line from pin 20
        wr(A_TRIG2, 32'h77737777);
        wr(A_MASK2, 32'h000000EF);
        pins[20] = 1'b1; step(3);
        chk("R10 shared raised", {15'h0, irq_shared, irq_line}, 32'h00010000);
        wr(A_MASK2, 32'h000000FF);
        chk("R10 shared masked", {31'h0, irq_shared}, 32'h0);
        wr(A_PEND2, 32'h10);
        pins[20] = 1'b0;

        // R9: dedicated line of pin 9
        wr(A_TRIG1, 32'h77777737);
        wr(A_MASK1, 32'h000000FD);
        pins[9] = 1'b1; step(3);
        chk("R9 pin 9 line", {16'h0, irq_line}, 32'h0200);
        wr(A_PEND1, 32'h02);
        pins[9] = 1'b0; step(3);

        // Random phase against the model
        compare_on = 1'b1;
        for (int t = 0; t < 4000; t++) begin
            logic [31:0] act;
            act = model_active();
            chk("R9 random lines", {16'h0, irq_line}, {16'h0, act[15:0]});
            chk("R10 random shared", {31'h0, irq_shared}, {31'h0, |act[31:16]});
            pins      = pins ^ ($urandom & $urandom & $urandom);
            reg_we    = ($urandom % 3) == 0;
            reg_addr  = 4'($urandom);
            reg_wdata = $urandom;
            #0.5;
            chk("R2 random readback", reg_rdata, model_read(reg_addr));
            @(negedge clk);
        end
        reg_we = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule